// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects up to eight interrupt sources and presents one interrupt line to a processor. Each request input is edge-sensitive. A rising edge is caught in a request latch, and the latch holds until that level is acknowledged. A mask register, readable and writable, can disable any level. Priority is fixed: level 0 ranks highest and level 7 lowest.

The controller keeps an in-service set. It raises its interrupt output only when an unmasked pending level outranks every level now in service. A level in service therefore blocks itself and every level below it. A one-cycle acknowledge pulse takes the winning level. The block returns an 8-bit vector for that level, marks the level in service and clears its request latch. Software ends service by writing an end-of-interrupt command byte. The byte can be non-specific, which releases the top-ranked level in service, or specific, which releases a chosen level. The vector base is a parameter.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset the mask reads 0xFF (all levels masked), no request is latched, no level is in service, and `int_out` and `vec_valid` are low.
- R2: A `mask_wr` pulse loads `mask_wdata` into the mask, and `mask_rdata` shows it from the next cycle. Bit n set to 1 disables level n. Bit n set to 0 enables it.
- R3: A rising edge on `irq_in[n]` latches a request, which is visible on `int_out` in the cycle after the edge. A level held high produces no second request after it is acknowledged.
- R4: Level 0 has the highest priority and level 7 the lowest. When several eligible requests are pending, an acknowledge picks the lowest-numbered one.
- R5: An `inta` pulse with an eligible winner n gives `vec_valid` high and `vec_out` = VEC_BASE + n in the next cycle. The same pulse puts level n in service and clears its request latch.
- R6: `int_out` is high only when an unmasked pending level has a smaller index than every level in service. A level in service blocks itself and all higher-numbered levels. Smaller-numbered levels can still interrupt.
- R7: A command byte with bits 7:5 = 001 and bits 4:3 = 00 is a non-specific end-of-interrupt. It releases the lowest-numbered level in service, whatever bits 2:0 hold.
- R8: A command byte with bits 7:5 = 011 and bits 4:3 = 00 is a specific end-of-interrupt. It releases the level given by bits 2:0. For example, 0x64 releases level 4 and 0x62 releases level 2.
- R9: Every other command byte is ignored. This includes a byte whose bits 4:3 are nonzero, and any byte whose bits 7:5 are neither 001 nor 011.
- R10: If a request for a level was latched again while that level was in service, `int_out` rises in the cycle after the end-of-interrupt that releases it.
- R11: An acknowledge with no eligible winner returns VEC_BASE + 7 and changes neither the in-service set nor the request latches.
- R12: A masked level still latches its edges. Clearing its mask bit raises `int_out` without a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request inputs; bit n is level n |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte (end-of-interrupt encodings) |
| inta | input | 1 | Acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the acknowledged level |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |

## Verification
The bench nests service several levels deep. It then uses the levels still pending to show which in-service bit each command released. A non-specific release that cleared the wrong bit would leave a middle level blocked. A specific release that ignored bits 2:0 would let `int_out` rise too early or not at all.

Several other corners are covered. Malformed command bytes are sent while a lower level waits; a decoder that skipped the bits 4:3 check would unblock that level. A level is re-triggered while it is in service, to catch a design that drops the new edge or raises it too soon. An acknowledge is issued with nothing pending, to catch a design that marks level 7 in service on that path. A level is held high across its own release, to catch a level-sensitive latch that re-arms itself.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned LEVELS = 8;
    localparam int unsigned IDX_W  = $clog2(LEVELS);
    localparam int unsigned CMD_W  = 8;

    typedef logic [LEVELS-1:0] lvl_vec_t;
    typedef logic [IDX_W-1:0]  lvl_idx_t;

    // command opcode field, bits 7:5 of the command byte
    typedef enum logic [2:0] {
        OPC_RELEASE_TOP = 3'b001,
        OPC_RELEASE_ONE = 3'b011
    } eoi_opc_e;

    typedef struct packed {
        logic     hit;
        lvl_idx_t idx;
    } pick_t;

    typedef struct packed {
        logic     clr_top;
        logic     clr_one;
        lvl_idx_t idx;
    } eoi_t;

    // lowest set index wins (index 0 ranks highest)
    function automatic pick_t pick_highest(lvl_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = lvl_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t idx_onehot(lvl_idx_t i);
        return lvl_vec_t'(1) << i;
    endfunction

    // levels that outrank the given in-service top; all when none in service
    function automatic lvl_vec_t outrank_mask(pick_t top);
        if (!top.hit)
            return '1;
        return (lvl_vec_t'(1) << top.idx) - lvl_vec_t'(1);
    endfunction

endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t irq_in,
    input  lvl_vec_t clr,
    output lvl_vec_t req
);

    lvl_vec_t irq_prev;
    lvl_vec_t edge_det;

    assign edge_det = irq_in & ~irq_prev;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_prev[g] <= 1'b0;
                req[g]      <= 1'b0;
            end else begin
                irq_prev[g] <= irq_in[g];
                req[g]      <= (req[g] & ~clr[g]) | edge_det[g];
            end
        end

        AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !edge_det[g]) |=> !req[g]); // R5

        AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
            edge_det[g] |=> req[g]); // R3
    end

endmodule

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode
    import intc_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    output eoi_t             eoi
);

    logic     fmt_ok;
    eoi_opc_e opc;

    assign opc    = eoi_opc_e'(cmd_data[7:5]);
    assign fmt_ok = cmd_wr && (cmd_data[4:3] == 2'b00);

    always_comb begin
        eoi.clr_top = 1'b0;
        eoi.clr_one = 1'b0;
        eoi.idx     = cmd_data[IDX_W-1:0];
        if (fmt_ok) begin
            case (opc)
                OPC_RELEASE_TOP: eoi.clr_top = 1'b1;
                OPC_RELEASE_ONE: eoi.clr_one = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (!cmd_wr)
            AST_NO_CMD_NO_EOI: assert (!eoi.clr_top && !eoi.clr_one); // R9
    end

endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
    import intc_pkg::*;
(
    input  lvl_vec_t req,
    input  lvl_vec_t mask,
    input  lvl_vec_t isr,
    output pick_t    win
);

    lvl_vec_t pending;
    lvl_vec_t eligible;
    pick_t    isr_top;

    assign pending  = req & ~mask;
    assign isr_top  = pick_highest(isr);
    assign eligible = pending & outrank_mask(isr_top);
    assign win      = pick_highest(eligible);

    always_comb begin
        if (win.hit && isr_top.hit)
            AST_WIN_OUTRANKS: assert (win.idx < isr_top.idx); // R6
    end

endmodule

// File: rtl/intc_service.sv
module intc_service
    import intc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inta,
    input  pick_t      win,
    input  eoi_t       eoi,
    output lvl_vec_t   isr,
    output lvl_vec_t   ack_clr,
    output logic [7:0] vec_out,
    output logic       vec_valid
);

    localparam lvl_idx_t SPUR_IDX = lvl_idx_t'(LEVELS - 1);

    lvl_vec_t ack_set;
    lvl_vec_t eoi_clr;
    pick_t    isr_top;
    lvl_idx_t vec_idx;
    logic     ack_fire;

    assign ack_fire = inta && win.hit;
    assign ack_set  = ack_fire ? idx_onehot(win.idx) : '0;
    assign ack_clr  = ack_set;
    assign isr_top  = pick_highest(isr);
    assign vec_idx  = win.hit ? win.idx : SPUR_IDX;

    always_comb begin
        eoi_clr = '0;
        if (eoi.clr_top && isr_top.hit)
            eoi_clr = eoi_clr | idx_onehot(isr_top.idx);
        if (eoi.clr_one)
            eoi_clr = eoi_clr | idx_onehot(eoi.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            isr       <= (isr & ~eoi_clr) | ack_set;
            vec_valid <= inta;
            if (inta)
                vec_out <= VEC_BASE + 8'(vec_idx);
        end
    end

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta)); // R5

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> isr[$past(win.idx)]); // R5

    AST_ONE_ENTRY_PER_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_set)); // R5

    AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (inta && !win.hit && !eoi.clr_top && !eoi.clr_one) |=> $stable(isr)); // R11

    AST_SPECIFIC_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (eoi.clr_one && !(ack_fire && win.idx == eoi.idx)) |=> !isr[$past(eoi.idx)]); // R8

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       mask_wr,
    input  logic [7:0] mask_wdata,
    output logic [7:0] mask_rdata,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       inta,
    output logic       int_out,
    output logic [7:0] vec_out,
    output logic       vec_valid
);

    lvl_vec_t mask_q;
    lvl_vec_t req;
    lvl_vec_t isr;
    lvl_vec_t ack_clr;
    pick_t    win;
    eoi_t     eoi;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    assign mask_rdata = mask_q;
    assign int_out    = win.hit;

    intc_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .clr    (ack_clr),
        .req    (req)
    );

    intc_cmd_decode u_cmd (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .eoi      (eoi)
    );

    intc_resolver u_res (
        .req  (req),
        .mask (mask_q),
        .isr  (isr),
        .win  (win)
    );

    intc_service #(.VEC_BASE(VEC_BASE)) u_svc (
        .clk       (clk),
        .rst       (rst),
        .inta      (inta),
        .win       (win),
        .eoi       (eoi),
        .isr       (isr),
        .ack_clr   (ack_clr),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_rdata == $past(mask_wdata))); // R2

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((req & ~mask_q) != '0)); // R12

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;

    localparam logic [7:0] BASE = 8'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       inta = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    prio_intc #(.VEC_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .inta(inta),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // monitor: pops expected vectors as the design produces them
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected vector: actual %02h expected none", vec_out);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (vec_out !== e) begin
                    fails++;
                    $display("FAIL %s vector: actual %02h expected %02h", t, vec_out, e);
                end
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", what, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [7:0] v);
        @(negedge clk); mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_data = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] bits);
        @(negedge clk); irq_in = irq_in | bits;
        @(negedge clk); irq_in = irq_in & ~bits;
    endtask

    // driver: pushes the expected vector, then issues the acknowledge
    task automatic ack(input int lvl, input string t);
        exp_q.push_back(BASE + 8'(lvl));
        tag_q.push_back(t);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(int_out, 1'b0, "R1 int_out after reset");
        check(vec_valid, 1'b0, "R1 vec_valid after reset");
        check8(mask_rdata, 8'hFF, "R1 mask after reset");

        // R2
        wr_mask(8'hA5);
        check8(mask_rdata, 8'hA5, "R2 mask readback");
        wr_mask(8'h00);
        check8(mask_rdata, 8'h00, "R2 mask cleared");

        // R3 / R5
        pulse(8'h08);
        check(int_out, 1'b1, "R3 edge on level 3 raises int_out");
        ack(3, "R5 ack level 3");
        check(int_out, 1'b0, "R5 request cleared after ack");

        // R6: lower level blocked, higher level passes
        pulse(8'h20);
        check(int_out, 1'b0, "R6 level 5 blocked by level 3");
        pulse(8'h02);
        check(int_out, 1'b1, "R6 level 1 outranks level 3");
        ack(1, "R6 ack level 1");
        check(int_out, 1'b0, "R6 nested service blocks level 5");

        // R9: malformed bytes are ignored
        wr_cmd(8'h38);
        check(int_out, 1'b0, "R9 bits 4:3 nonzero ignored");
        wr_cmd(8'hE0);
        check(int_out, 1'b0, "R9 opcode 111 ignored");
        wr_cmd(8'h43);
        check(int_out, 1'b0, "R9 opcode 010 ignored");

        // R7: non-specific release clears level 1 only
        wr_cmd(8'h25);
        check(int_out, 1'b0, "R7 level 3 still blocks level 5");
        pulse(8'h04);
        check(int_out, 1'b1, "R7 level 2 unblocked once level 1 released");
        ack(2, "R7 ack level 2");

        // R8: specific releases
        wr_cmd(8'h63);
        check(int_out, 1'b0, "R8 level 2 still blocks level 5");
        wr_cmd(8'h62);
        check(int_out, 1'b1, "R8 levels 2 and 3 released, level 5 raised");
        ack(5, "R8 ack level 5");

        // R10: re-trigger while in service
        pulse(8'h20);
        check(int_out, 1'b0, "R10 level 5 blocks itself");
        wr_cmd(8'h65);
        check(int_out, 1'b1, "R10 pending level 5 raised after release");
        ack(5, "R10 ack level 5 again");
        wr_cmd(8'h65);
        check(int_out, 1'b0, "R10 nothing pending after second release");

        // R11: spurious acknowledge
        ack(7, "R11 spurious vector");
        check(int_out, 1'b0, "R11 no interrupt after spurious ack");
        pulse(8'h80);
        check(int_out, 1'b1, "R11 level 7 not put in service by spurious ack");
        ack(7, "R11 real level 7");
        wr_cmd(8'h67);

        // R12: masked edge stays latched
        wr_mask(8'h01);
        pulse(8'h01);
        check(int_out, 1'b0, "R12 masked level 0 silent");
        wr_mask(8'h00);
        check(int_out, 1'b1, "R12 unmask raises level 0");
        ack(0, "R12 ack level 0");
        wr_cmd(8'h20);

        // R3: held level does not re-arm
        @(negedge clk); irq_in[4] = 1'b1;
        @(negedge clk);
        check(int_out, 1'b1, "R3 held level 4 raises");
        ack(4, "R3 ack level 4");
        wr_cmd(8'h64);
        check(int_out, 1'b0, "R3 held level gives no second request");
        @(negedge clk); irq_in[4] = 1'b0;

        // R4: simultaneous requests
        pulse(8'h44);
        check(int_out, 1'b1, "R4 simultaneous levels 2 and 6");
        ack(2, "R4 level 2 wins");
        check(int_out, 1'b0, "R4 level 6 blocked by 2");
        wr_cmd(8'h20);
        check(int_out, 1'b1, "R4 level 6 after release");
        ack(6, "R4 level 6 next");
        wr_cmd(8'h20);
        check(int_out, 1'b0, "R4 all released");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5 vectors missing: actual %0d left expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule